// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block is a small shelving buffer that sits between instruction decode and one execution unit. Operands are read from the register file at issue time, and each source arrives either as a value or as the tag of the instruction that will produce it. A source that is still pending holds that tag until a matching result is broadcast. Every entry watches the result bus and compares its pending tags with the broadcast destination identifier. On a hit the entry copies the value into the source and marks it valid.

An entry whose two sources are both valid may go to the execution unit. When several entries are ready, the one issued earliest wins. Each entry carries a relative age that is decremented as older entries leave, so the smallest age is always the oldest. An optional bypass lets an instruction with ready operands go straight to the dispatch port in its own issue cycle, but only when the station is empty.

Issue and dispatch are valid/ready streams. Issue back-pressure is `iss_ready`, which is low only when every entry is occupied, and an issue presented while it is low is not taken. Dispatch back-pressure is `dsp_ready`. Once raised, `dsp_valid` stays high until a transfer occurs. The payload may switch to an older entry that became ready in the meantime.

Top module: `shelf_rs`

## Requirements
- R1: After reset the station is empty: `iss_ready` is 1 and, with no issue presented, `dsp_valid` is 0.
- R2: An issue transfers when `iss_valid` and `iss_ready` are both 1. With bypass off, an instruction whose operands are ready is offered on the dispatch port no earlier than the cycle after it was issued.
- R3: Source encoding at issue: when `iss_a_ok`/`iss_b_ok` is 1 the field holds the operand value. When it is 0, the field's low TAG_W bits hold the producer tag.
- R4: A result with `res_valid`=1 whose `res_tag` equals a pending source tag stores `res_data` into that source and sets its valid bit. All matching sources capture in the same cycle. The entry can be dispatched from the next cycle. A non-matching tag changes nothing.
- R5: If a result is broadcast in the same cycle as an issue that waits on that tag, the broadcast value is taken into the new instruction as a valid operand.
- R6: An entry is offered for dispatch only when both of its sources are valid.
- R7: Among ready entries, the earliest issued is offered first.
- R8: At most one instruction leaves per cycle, on `dsp_valid` and `dsp_ready`. While `dsp_ready` is 0, `dsp_valid` stays 1. A dispatched entry is removed.
- R9: With bypass on, an empty station, and an issue whose operands are ready (including by R5), the issue appears on the dispatch port in the same cycle. If `dsp_ready` is 1 the instruction is not stored; otherwise it is stored and offered from the next cycle.
- R10: After DEPTH instructions are held, `iss_ready` is 0. It returns to 1 the cycle after one of them is dispatched.
- R11: A broadcast whose tag equals the value held in an already valid source does not change that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A free entry exists |
| iss_opc | input | OPC_W | Opcode |
| iss_a_ok | input | 1 | Source A holds a value |
| iss_a | input | DATA_W | Source A value or producer tag |
| iss_b_ok | input | 1 | Source B holds a value |
| iss_b | input | DATA_W | Source B value or producer tag |
| iss_dst | input | TAG_W | Destination register identifier |
| res_valid | input | 1 | Result broadcast present |
| res_tag | input | TAG_W | Destination identifier of the result |
| res_data | input | DATA_W | Result value |
| dsp_valid | output | 1 | Instruction offered to the execution unit |
| dsp_ready | input | 1 | Execution unit accepts |
| dsp_opc | output | OPC_W | Dispatched opcode |
| dsp_a | output | DATA_W | Dispatched source A value |
| dsp_b | output | DATA_W | Dispatched source B value |
| dsp_dst | output | TAG_W | Dispatched destination identifier |

## Verification
The bench issues a young ready instruction behind an older waiting one and then wakes the older one. A design that picks by slot index or by readiness alone would dispatch in the wrong order. It broadcasts a result in the same cycle as an issue that waits on it; a design without forwarding would leave that entry waiting forever. It broadcasts a tag equal to a held operand value; a design that compares without checking the valid bit would corrupt the operand. It fills the station, drains one entry and checks the bypass both when it is taken and when it is refused. Errors there show up as overwritten entries, lost instructions or a duplicated dispatch.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
  typedef enum logic {BYPASS_OFF = 1'b0, BYPASS_ON = 1'b1} bypass_e;
endpackage

// File: rtl/rs_slot.sv
`timescale 1ns/1ps
module rs_slot #(
  parameter int OPC_W  = 6,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5,
  parameter int AGE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OPC_W-1:0]  wr_opc,
  input  logic              wr_a_ok,
  input  logic [DATA_W-1:0] wr_a,
  input  logic              wr_b_ok,
  input  logic [DATA_W-1:0] wr_b,
  input  logic [TAG_W-1:0]  wr_dst,
  input  logic [AGE_W-1:0]  wr_age,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              take,
  input  logic              age_dec,
  output logic              busy,
  output logic              rdy,
  output logic [OPC_W-1:0]  opc,
  output logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] b,
  output logic [TAG_W-1:0]  dst,
  output logic [AGE_W-1:0]  age
);
  logic a_ok_q, b_ok_q;
  logic hit_a, hit_b;

  // compare only sources still waiting for a producer
  assign hit_a = busy && !a_ok_q && bc_valid && (bc_tag == a[TAG_W-1:0]);
  assign hit_b = busy && !b_ok_q && bc_valid && (bc_tag == b[TAG_W-1:0]);
  assign rdy   = busy && a_ok_q && b_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      a_ok_q <= 1'b0;
      b_ok_q <= 1'b0;
      opc    <= '0;
      a      <= '0;
      b      <= '0;
      dst    <= '0;
      age    <= '0;
    end else if (wr_en) begin
      busy   <= 1'b1;
      opc    <= wr_opc;
      a_ok_q <= wr_a_ok;
      a      <= wr_a;
      b_ok_q <= wr_b_ok;
      b      <= wr_b;
      dst    <= wr_dst;
      age    <= wr_age;
    end else begin
      if (take)    busy <= 1'b0;
      if (age_dec) age  <= age - 1'b1;
      if (hit_a) begin
        a      <= bc_data;
        a_ok_q <= 1'b1;
      end
      if (hit_b) begin
        b      <= bc_data;
        b_ok_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_pick.sv
`timescale 1ns/1ps
module rs_pick #(
  parameter int DEPTH = 4,
  parameter int AGE_W = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            rdy,
  input  logic [DEPTH-1:0][AGE_W-1:0] age,
  output logic                        found,
  output logic [IDX_W-1:0]            idx
);
  logic [AGE_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rdy[i] && (!found || age[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = age[i];
      end
    end
  end
endmodule

// File: rtl/rs_freefind.sv
`timescale 1ns/1ps
module rs_freefind #(
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] busy,
  output logic             has_free,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    has_free = 1'b0;
    idx      = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        has_free = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/shelf_rs.sv
`timescale 1ns/1ps
module shelf_rs
  import rs_pkg::*;
#(
  parameter int      DEPTH  = 4,
  parameter int      OPC_W  = 6,
  parameter int      DATA_W = 32,
  parameter int      TAG_W  = 5,
  parameter bypass_e BYPASS = BYPASS_ON
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [OPC_W-1:0]  iss_opc,
  input  logic              iss_a_ok,
  input  logic [DATA_W-1:0] iss_a,
  input  logic              iss_b_ok,
  input  logic [DATA_W-1:0] iss_b,
  input  logic [TAG_W-1:0]  iss_dst,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  output logic              dsp_valid,
  input  logic              dsp_ready,
  output logic [OPC_W-1:0]  dsp_opc,
  output logic [DATA_W-1:0] dsp_a,
  output logic [DATA_W-1:0] dsp_b,
  output logic [TAG_W-1:0]  dsp_dst
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int AGE_W = IDX_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]             slot_busy, slot_rdy;
  logic [DEPTH-1:0][OPC_W-1:0]  slot_opc;
  logic [DEPTH-1:0][DATA_W-1:0] slot_a, slot_b;
  logic [DEPTH-1:0][TAG_W-1:0]  slot_dst;
  logic [DEPTH-1:0][AGE_W-1:0]  slot_age;

  logic              fwd_a, fwd_b, in_a_ok, in_b_ok;
  logic [DATA_W-1:0] in_a, in_b;
  logic              has_free, found, byp_cand, byp_take, st_fire, alloc;
  logic [IDX_W-1:0]  free_idx, pick_idx;
  logic [CNT_W-1:0]  occ, age_calc;
  logic [AGE_W-1:0]  new_age, sel_age;

  // same-cycle forwarding of a broadcast into the issuing instruction
  assign fwd_a   = !iss_a_ok && res_valid && (res_tag == iss_a[TAG_W-1:0]);
  assign fwd_b   = !iss_b_ok && res_valid && (res_tag == iss_b[TAG_W-1:0]);
  assign in_a_ok = iss_a_ok | fwd_a;
  assign in_b_ok = iss_b_ok | fwd_b;
  assign in_a    = fwd_a ? res_data : iss_a;
  assign in_b    = fwd_b ? res_data : iss_b;

  rs_freefind #(.DEPTH(DEPTH)) u_free (
    .busy(slot_busy), .has_free(has_free), .idx(free_idx)
  );

  rs_pick #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_pick (
    .rdy(slot_rdy), .age(slot_age), .found(found), .idx(pick_idx)
  );

  always_comb begin
    occ = '0;
    for (int i = 0; i < DEPTH; i++) occ = occ + CNT_W'(slot_busy[i]);
  end

  generate
    if (BYPASS == BYPASS_ON) begin : g_byp
      assign byp_cand = iss_valid && (slot_busy == '0) && in_a_ok && in_b_ok;
    end else begin : g_nobyp
      assign byp_cand = 1'b0;
    end
  endgenerate

  assign iss_ready = has_free;
  assign byp_take  = byp_cand && dsp_ready;
  assign st_fire   = found && dsp_ready;
  assign alloc     = iss_valid && has_free && !byp_take;
  assign age_calc  = occ - CNT_W'(st_fire);
  assign new_age   = age_calc[AGE_W-1:0];
  assign sel_age   = slot_age[pick_idx];

  assign dsp_valid = byp_cand | found;
  assign dsp_opc   = byp_cand ? iss_opc : slot_opc[pick_idx];
  assign dsp_a     = byp_cand ? in_a    : slot_a[pick_idx];
  assign dsp_b     = byp_cand ? in_b    : slot_b[pick_idx];
  assign dsp_dst   = byp_cand ? iss_dst : slot_dst[pick_idx];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      rs_slot #(.OPC_W(OPC_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (alloc && (free_idx == IDX_W'(g))),
        .wr_opc  (iss_opc),
        .wr_a_ok (in_a_ok),
        .wr_a    (in_a),
        .wr_b_ok (in_b_ok),
        .wr_b    (in_b),
        .wr_dst  (iss_dst),
        .wr_age  (new_age),
        .bc_valid(res_valid),
        .bc_tag  (res_tag),
        .bc_data (res_data),
        .take    (st_fire && (pick_idx == IDX_W'(g))),
        .age_dec (st_fire && slot_busy[g] && (slot_age[g] > sel_age)),
        .busy    (slot_busy[g]),
        .rdy     (slot_rdy[g]),
        .opc     (slot_opc[g]),
        .a       (slot_a[g]),
        .b       (slot_b[g]),
        .dst     (slot_dst[g]),
        .age     (slot_age[g])
      );
    end
  endgenerate
endmodule

// File: rtl/shelf_rs_chk.sv
`timescale 1ns/1ps
module shelf_rs_chk #(
  parameter int DEPTH = 4,
  parameter int AGE_W = 2,
  parameter int IDX_W = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        iss_valid,
  input logic                        iss_ready,
  input logic                        dsp_valid,
  input logic                        dsp_ready,
  input logic                        byp_cand,
  input logic                        found,
  input logic [IDX_W-1:0]            pick_idx,
  input logic [DEPTH-1:0]            busy,
  input logic [DEPTH-1:0]            rdy,
  input logic [DEPTH-1:0][AGE_W-1:0] age
);
  // R8
  dsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid && !dsp_ready |=> dsp_valid);

  // R6
  dsp_operands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid && !byp_cand |-> rdy[pick_idx]);

  // R9
  bypass_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_cand |-> (busy == '0));

  // R10
  full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |-> ($countones(busy) == DEPTH));

  // R2
  alloc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready && !dsp_ready |=> ($countones(busy) == $past($countones(busy)) + 1));

  // R7
  always @(posedge clk) begin
    if (rst_n && found) begin
      for (int j = 0; j < DEPTH; j++) begin
        oldest_chk: assert (!rdy[j] || age[pick_idx] <= age[j]);
      end
    end
  end
endmodule

bind shelf_rs shelf_rs_chk #(.DEPTH(DEPTH), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iss_valid(iss_valid),
  .iss_ready(iss_ready),
  .dsp_valid(dsp_valid),
  .dsp_ready(dsp_ready),
  .byp_cand (byp_cand),
  .found    (found),
  .pick_idx (pick_idx),
  .busy     (slot_busy),
  .rdy      (slot_rdy),
  .age      (slot_age)
);

// File: tb/shelf_rs_tb.sv
`timescale 1ns/1ps
module shelf_rs_tb;
  import rs_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid, iss_a_ok, iss_b_ok, res_valid, dsp_ready;
  logic [5:0]  iss_opc;
  logic [31:0] iss_a, iss_b, res_data;
  logic [4:0]  iss_dst, res_tag;

  logic        d_iss_ready, d_dsp_valid, n_iss_ready, n_dsp_valid;
  logic [5:0]  d_dsp_opc, n_dsp_opc;
  logic [31:0] d_dsp_a, d_dsp_b, n_dsp_a, n_dsp_b;
  logic [4:0]  d_dsp_dst, n_dsp_dst;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk; // 50 MHz

  shelf_rs #(.BYPASS(BYPASS_ON)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(d_iss_ready), .iss_opc(iss_opc),
    .iss_a_ok(iss_a_ok), .iss_a(iss_a), .iss_b_ok(iss_b_ok), .iss_b(iss_b), .iss_dst(iss_dst),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .dsp_valid(d_dsp_valid), .dsp_ready(dsp_ready), .dsp_opc(d_dsp_opc),
    .dsp_a(d_dsp_a), .dsp_b(d_dsp_b), .dsp_dst(d_dsp_dst)
  );

  shelf_rs #(.BYPASS(BYPASS_OFF)) u_nob (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(n_iss_ready), .iss_opc(iss_opc),
    .iss_a_ok(iss_a_ok), .iss_a(iss_a), .iss_b_ok(iss_b_ok), .iss_b(iss_b), .iss_dst(iss_dst),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .dsp_valid(n_dsp_valid), .dsp_ready(dsp_ready), .dsp_opc(n_dsp_opc),
    .dsp_a(n_dsp_a), .dsp_b(n_dsp_b), .dsp_dst(n_dsp_dst)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    iss_valid = 1'b0; iss_a_ok = 1'b1; iss_b_ok = 1'b1;
    iss_a = '0; iss_b = '0; iss_opc = '0; iss_dst = '0;
    res_valid = 1'b0; res_tag = '0; res_data = '0;
  endtask

  task automatic issue(input logic [5:0] op, input logic aok, input logic [31:0] a,
                       input logic bok, input logic [31:0] b, input logic [4:0] dst);
    iss_valid = 1'b1; iss_opc = op; iss_a_ok = aok; iss_a = a;
    iss_b_ok = bok; iss_b = b; iss_dst = dst;
  endtask

  task automatic bcast(input logic [4:0] tag, input logic [31:0] data);
    res_valid = 1'b1; res_tag = tag; res_data = data;
  endtask

  task automatic do_reset();
    idle();
    dsp_ready = 1'b0;
    rst_n = 1'b0;
    nxt(); nxt();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1", "iss_ready bypass", {31'b0, d_iss_ready}, 1);
    chk("R1", "dsp_valid bypass", {31'b0, d_dsp_valid}, 0);
    chk("R1", "iss_ready nobyp", {31'b0, n_iss_ready}, 1);
    chk("R1", "dsp_valid nobyp", {31'b0, n_dsp_valid}, 0);
  endtask

  task automatic t_basic();
    do_reset();
    dsp_ready = 1'b1;
    issue(6'd7, 1'b1, 32'h1111, 1'b1, 32'h2222, 5'd4);
    #1;
    chk("R2", "no same-cycle offer", {31'b0, n_dsp_valid}, 0);
    nxt(); idle(); #1;
    chk("R2", "offered next cycle", {31'b0, n_dsp_valid}, 1);
    chk("R3", "value A", n_dsp_a, 32'h1111);
    chk("R3", "value B", n_dsp_b, 32'h2222);
    chk("R2", "opcode", {26'b0, n_dsp_opc}, 7);
    nxt(); #1;
    chk("R8", "removed after dispatch", {31'b0, n_dsp_valid}, 0);
  endtask

  task automatic t_capture();
    do_reset();
    dsp_ready = 1'b1;
    issue(6'd1, 1'b0, 32'd3, 1'b0, 32'd3, 5'd8);
    nxt(); idle(); #1;
    chk("R6", "waiting entry held", {31'b0, n_dsp_valid}, 0);
    bcast(5'd7, 32'hDEAD);
    nxt(); idle(); #1;
    chk("R4", "other tag ignored", {31'b0, n_dsp_valid}, 0);
    bcast(5'd3, 32'hAAAA);
    #1;
    chk("R4", "not ready in capture cycle", {31'b0, n_dsp_valid}, 0);
    nxt(); idle(); #1;
    chk("R4", "ready after capture", {31'b0, n_dsp_valid}, 1);
    chk("R4", "captured A", n_dsp_a, 32'hAAAA);
    chk("R4", "captured B", n_dsp_b, 32'hAAAA);
    nxt();
  endtask

  task automatic t_forward();
    do_reset();
    dsp_ready = 1'b1;
    issue(6'd2, 1'b0, 32'd2, 1'b1, 32'h5, 5'd9);
    bcast(5'd2, 32'h1234);
    nxt(); idle(); #1;
    chk("R5", "forwarded ready", {31'b0, n_dsp_valid}, 1);
    chk("R5", "forwarded value", n_dsp_a, 32'h1234);
    nxt();
  endtask

  task automatic t_oldest();
    do_reset();
    dsp_ready = 1'b0;
    issue(6'd1, 1'b0, 32'd1, 1'b1, 32'h20, 5'd10);
    nxt();
    issue(6'd1, 1'b1, 32'h11, 1'b1, 32'h21, 5'd11);
    nxt();
    issue(6'd1, 1'b1, 32'h12, 1'b1, 32'h22, 5'd12);
    #1;
    chk("R7", "only ready offered", {27'b0, n_dsp_dst}, 11);
    nxt(); idle(); #1;
    chk("R7", "older ready first", {27'b0, n_dsp_dst}, 11);
    chk("R8", "valid held while stalled", {31'b0, n_dsp_valid}, 1);
    bcast(5'd1, 32'h100);
    nxt(); idle(); #1;
    chk("R7", "oldest after wakeup", {27'b0, n_dsp_dst}, 10);
    chk("R4", "wakeup value", n_dsp_a, 32'h100);
    dsp_ready = 1'b1;
    nxt(); #1;
    chk("R7", "second oldest", {27'b0, n_dsp_dst}, 11);
    nxt(); #1;
    chk("R7", "youngest last", {27'b0, n_dsp_dst}, 12);
    nxt(); #1;
    chk("R8", "drained", {31'b0, n_dsp_valid}, 0);
  endtask

  task automatic t_full();
    do_reset();
    dsp_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      issue(6'd3, 1'b0, 32'(k + 1), 1'b1, 32'h0, 5'(20 + k));
      nxt();
    end
    idle(); #1;
    chk("R10", "full", {31'b0, n_iss_ready}, 0);
    bcast(5'd2, 32'h7);
    nxt(); idle(); #1;
    chk("R10", "ready one dispatchable", {27'b0, n_dsp_dst}, 21);
    chk("R10", "still full", {31'b0, n_iss_ready}, 0);
    dsp_ready = 1'b1;
    nxt(); #1;
    chk("R10", "free after dispatch", {31'b0, n_iss_ready}, 1);
    chk("R8", "one per cycle", {31'b0, n_dsp_valid}, 0);
  endtask

  task automatic t_noclobber();
    do_reset();
    dsp_ready = 1'b0;
    issue(6'd4, 1'b1, 32'd9, 1'b0, 32'd6, 5'd3);
    nxt(); idle();
    bcast(5'd9, 32'hBEEF);
    nxt(); idle();
    bcast(5'd6, 32'h66);
    nxt(); idle(); #1;
    chk("R11", "valid source kept", n_dsp_a, 32'd9);
    chk("R4", "pending source captured", n_dsp_b, 32'h66);
  endtask

  task automatic t_bypass();
    do_reset();
    dsp_ready = 1'b1;
    issue(6'd3, 1'b1, 32'h55, 1'b1, 32'h66, 5'd5);
    #1;
    chk("R9", "same-cycle offer", {31'b0, d_dsp_valid}, 1);
    chk("R9", "bypass dst", {27'b0, d_dsp_dst}, 5);
    chk("R9", "bypass A", d_dsp_a, 32'h55);
    nxt(); idle(); #1;
    chk("R9", "not stored", {31'b0, d_dsp_valid}, 0);
    issue(6'd3, 1'b0, 32'd4, 1'b1, 32'h1, 5'd6);
    bcast(5'd4, 32'h44);
    #1;
    chk("R9", "bypass with forward", {31'b0, d_dsp_valid}, 1);
    chk("R5", "bypass forwarded A", d_dsp_a, 32'h44);
    nxt(); idle();
    issue(6'd3, 1'b0, 32'd14, 1'b1, 32'h1, 5'd7);
    #1;
    chk("R9", "pending not bypassed", {31'b0, d_dsp_valid}, 0);
    nxt(); idle();
    dsp_ready = 1'b0;
    bcast(5'd14, 32'h60);
    nxt(); idle(); #1;
    chk("R9", "stored one after capture", {27'b0, d_dsp_dst}, 7);
    dsp_ready = 1'b1;
    nxt(); idle();
    dsp_ready = 1'b0;
    issue(6'd3, 1'b1, 32'h9, 1'b1, 32'h9, 5'd9);
    #1;
    chk("R9", "offered while stalled", {31'b0, d_dsp_valid}, 1);
    nxt(); idle(); #1;
    chk("R9", "stored when refused", {27'b0, d_dsp_dst}, 9);
    chk("R8", "held valid", {31'b0, d_dsp_valid}, 1);
    dsp_ready = 1'b1;
    nxt(); #1;
    chk("R8", "gone after accept", {31'b0, d_dsp_valid}, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    dsp_ready = 1'b0;
    idle();
    @(negedge clk);
    t_reset();
    t_basic();
    t_capture();
    t_forward();
    t_oldest();
    t_full();
    t_noclobber();
    t_bypass();
    finish_run();
  end
endmodule